// File: doc/BRIEF.md
# SPI Master Register and Status Unit

This block is the word-addressed register front end of a four-channel SPI master. A host reads and writes 32-bit registers over a simple request bus. Writes to the transmit-data port fill a transmit queue, and reads of the receive-data port drain a receive queue. The block also holds the control, configuration, interrupt-enable, DMA, period and test registers. It drives an active-low chip select for each channel and one level-sensitive interrupt. Status flags follow the queue levels, and interrupt-enable bits mask those flags onto the interrupt line.

The serial shifter sits outside the block. When the controller is enabled, the selected channel is a master and a launch condition holds, the block pops the oldest transmit word and pulses `xfer_start_o` with that word. The shifter later pulses `xfer_done_i` with the word it received, and the block stores it in the receive queue. Only one word is in flight at a time. A control write that leaves the enable bit clear returns the whole unit to its reset state.

Top module: `spi_reg_unit`

## Requirements
- R1: The word index is `bus_addr_i` (byte offset bits above bit 1). Index 0 is receive data, 1 transmit data, 2 control, 3 configuration, 4 interrupt enable, 5 DMA, 6 status, 7 period, 8 test and 9 message data. Indices 3, 4, 5, 7 and 8 store and return the full written word. An index above 9 reads 0 and ignores writes. When there is no read request, `bus_rdata_o` is 0.
- R2: Status bits are: 0 TX empty, 1 TX full, 2 RX not empty, 3 RX full, 4 RX overflow, 5 transfer complete. All other bits read 0. Bits 0 to 3 always reflect the current queue levels.
- R3: `irq_o` is high exactly when (status AND interrupt-enable) is nonzero.
- R4: A write to status clears bit 4 and/or bit 5 only where the written word has a 1 there. Every other status bit is unaffected by the write.
- R5: A read of receive data returns 0 when the controller is disabled (control bit 0 clear) or the RX queue is empty. Otherwise it returns the oldest RX word and removes it.
- R6: Reads of transmit data and message data return 0. Writes to receive data and message data change no state.
- R7: A write to transmit data is dropped when the controller is disabled or the TX queue holds DEPTH words. Otherwise the word is appended.
- R8: A control write with bit 0 clear clears every register, empties both queues, clears bits 4 and 5 and abandons any word in flight.
- R9: Control bits [19:18] select a channel, and control bits [7:4] mark each channel as master (bit 4 plus the channel number). When the selected channel is a master, its `cs_n_o` bit is 0 and the others are 1. Otherwise all are 1.
- R10: `xfer_start_o` pulses for one cycle, with `xfer_tx_o` equal to the head TX word, which is then popped. This happens when all of the following hold: the controller is enabled, the selected channel is a master, no word is in flight, the TX queue is not empty, and either control bit 3 (launch on write) or control bit 2 (exchange request) is set.
- R11: `xfer_done_i` while a word is in flight pushes `xfer_rx_i` into the RX queue. If the RX queue is full, the word is dropped and bit 4 is set. If the TX queue is empty at that moment, bit 5 is set and control bit 2 is cleared. `xfer_done_i` with no word in flight is ignored.
- R12: After reset, status reads 1, all other registers read 0, `irq_o` is 0 and `cs_n_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W-2 | Word index (byte offset >> 2) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Level interrupt |
| cs_n_o | output | NCS | Active-low chip selects |
| xfer_start_o | output | 1 | Launch pulse to the shifter |
| xfer_tx_o | output | 32 | Word to shift out |
| xfer_done_i | input | 1 | Shifter finished a word |
| xfer_rx_i | input | 32 | Word shifted in |

## Verification
Read data is due in the same cycle as the request, taken combinationally from the current state. Every state effect is visible from the next cycle. This covers pops, pushes, flag changes, W1C, the interrupt, the chip selects and the launch pulse. The bench drives each access just after a falling edge and compares every output against its behavioural model 1 ns later. It advances the model once per rising edge, using the same inputs the design sampled. A shifter model in the bench answers each launch with a done pulse three cycles later, so back-to-back transfers, RX overflow and the hardware clear of the exchange bit are all checked on their exact cycles.

// File: rtl/spi_ru_pkg.sv
package spi_ru_pkg;
  // word indices; order is decoded by software
  localparam int IX_RXD  = 0;
  localparam int IX_TXD  = 1;
  localparam int IX_CTRL = 2;
  localparam int IX_CFG  = 3;
  localparam int IX_IEN  = 4;
  localparam int IX_DMA  = 5;
  localparam int IX_STAT = 6;
  localparam int IX_PER  = 7;
  localparam int IX_TEST = 8;
  localparam int IX_MSG  = 9;
  // control fields
  localparam int C_EN   = 0;
  localparam int C_XCH  = 2;
  localparam int C_IMM  = 3;
  localparam int C_MODE = 4;
  localparam int C_SEL  = 18;
  // status bits
  localparam int S_TXE  = 0;
  localparam int S_TXF  = 1;
  localparam int S_RXR  = 2;
  localparam int S_RXF  = 3;
  localparam int S_OVF  = 4;
  localparam int S_DONE = 5;
endpackage

// File: rtl/spi_ru_fifo.sv
module spi_ru_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_ptr] <= data_i;
  end

  assign data_o  = mem[rd_ptr];
  assign count_o = cnt;
endmodule

// File: rtl/spi_ru_cs_dec.sv
module spi_ru_cs_dec #(
  parameter int NCS   = 4,
  parameter int SEL_W = 2
) (
  input  logic             master_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [NCS-1:0]   cs_n_o
);
  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n_o[g] = !(master_i && (sel_i == SEL_W'(g)));
  end
endmodule

// File: rtl/spi_reg_unit.sv
module spi_reg_unit #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12,
  parameter int NCS    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:2] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic [NCS-1:0]    cs_n_o,
  output logic              xfer_start_o,
  output logic [31:0]       xfer_tx_o,
  input  logic              xfer_done_i,
  input  logic [31:0]       xfer_rx_i
);
  import spi_ru_pkg::*;

  localparam int IW    = ADDR_W - 2;
  localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int CW    = $clog2(DEPTH+1);

  logic [IW-1:0] idx;
  logic wr, rd, wr_ctrl, soft_rst;
  logic [31:0] ctrl_q, cfg_q, ien_q, dma_q, per_q, test_q;
  logic ovf_q, done_q, busy_q;
  logic en, master, start, done_ok;
  logic [SEL_W-1:0] sel;
  logic [NCS-1:0] mode;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_push, rx_push, rx_pop;
  logic [31:0] rx_head, status;

  function automatic logic hit(input int n);
    return idx == IW'(n);
  endfunction

  assign idx      = bus_addr_i;
  assign wr       = bus_req_i && bus_we_i;
  assign rd       = bus_req_i && !bus_we_i;
  assign wr_ctrl  = wr && hit(IX_CTRL);
  assign soft_rst = wr_ctrl && !bus_wdata_i[C_EN];

  assign en     = ctrl_q[C_EN];
  assign sel    = ctrl_q[C_SEL +: SEL_W];
  assign mode   = ctrl_q[C_MODE +: NCS];
  assign master = mode[sel];

  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));

  assign start   = en && master && !busy_q && !tx_empty &&
                   (ctrl_q[C_XCH] || ctrl_q[C_IMM]);
  assign done_ok = xfer_done_i && busy_q;
  assign tx_push = wr && hit(IX_TXD) && en && !tx_full;
  assign rx_pop  = rd && hit(IX_RXD) && en && !rx_empty;
  assign rx_push = done_ok && !rx_full && !soft_rst;

  spi_ru_fifo #(.W(32), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (soft_rst),
    .push_i  (tx_push),
    .data_i  (bus_wdata_i),
    .pop_i   (start),
    .data_o  (xfer_tx_o),
    .count_o (tx_cnt)
  );

  spi_ru_fifo #(.W(32), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (soft_rst),
    .push_i  (rx_push),
    .data_i  (xfer_rx_i),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .count_o (rx_cnt)
  );

  spi_ru_cs_dec #(.NCS(NCS), .SEL_W(SEL_W)) u_cs_dec (
    .master_i (master),
    .sel_i    (sel),
    .cs_n_o   (cs_n_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; cfg_q <= '0; ien_q <= '0;
      dma_q  <= '0; per_q <= '0; test_q <= '0;
      ovf_q  <= 1'b0; done_q <= 1'b0; busy_q <= 1'b0;
    end else if (soft_rst) begin
      ctrl_q <= '0; cfg_q <= '0; ien_q <= '0;
      dma_q  <= '0; per_q <= '0; test_q <= '0;
      ovf_q  <= 1'b0; done_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      if (start)        busy_q <= 1'b1;
      else if (done_ok) busy_q <= 1'b0;
      // clear-on-one first, hardware set wins
      if (wr && hit(IX_STAT)) begin
        if (bus_wdata_i[S_OVF])  ovf_q  <= 1'b0;
        if (bus_wdata_i[S_DONE]) done_q <= 1'b0;
      end
      if (done_ok && rx_full) ovf_q <= 1'b1;
      if (done_ok && tx_empty) begin
        done_q         <= 1'b1;
        ctrl_q[C_XCH]  <= 1'b0;
      end
      if (wr_ctrl)             ctrl_q <= bus_wdata_i;
      if (wr && hit(IX_CFG))  cfg_q  <= bus_wdata_i;
      if (wr && hit(IX_IEN))  ien_q  <= bus_wdata_i;
      if (wr && hit(IX_DMA))  dma_q  <= bus_wdata_i;
      if (wr && hit(IX_PER))  per_q  <= bus_wdata_i;
      if (wr && hit(IX_TEST)) test_q <= bus_wdata_i;
    end
  end

  always_comb begin
    status         = '0;
    status[S_TXE]  = tx_empty;
    status[S_TXF]  = tx_full;
    status[S_RXR]  = !rx_empty;
    status[S_RXF]  = rx_full;
    status[S_OVF]  = ovf_q;
    status[S_DONE] = done_q;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (hit(IX_RXD))       bus_rdata_o = rx_pop ? rx_head : '0;
      else if (hit(IX_CTRL)) bus_rdata_o = ctrl_q;
      else if (hit(IX_CFG))  bus_rdata_o = cfg_q;
      else if (hit(IX_IEN))  bus_rdata_o = ien_q;
      else if (hit(IX_DMA))  bus_rdata_o = dma_q;
      else if (hit(IX_STAT)) bus_rdata_o = status;
      else if (hit(IX_PER))  bus_rdata_o = per_q;
      else if (hit(IX_TEST)) bus_rdata_o = test_q;
    end
  end

  assign irq_o        = |(status & ien_q);
  assign xfer_start_o = start;
endmodule

// File: rtl/spi_reg_unit_chk.sv
module spi_reg_unit_chk #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 12,
  parameter int NCS    = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       bus_req_i,
  input logic                       bus_we_i,
  input logic [ADDR_W-1:2]          bus_addr_i,
  input logic [31:0]                bus_wdata_i,
  input logic                       irq_o,
  input logic [NCS-1:0]             cs_n_o,
  input logic                       xfer_start_o,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic                       tx_full,
  input logic                       ovf_q,
  input logic [31:0]                ien_q
);
  localparam int IW = ADDR_W - 2;
  logic wr;
  assign wr = bus_req_i && bus_we_i;

  p_cs_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cs_n_o) <= 1);

  p_cs_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (~cs_n_o != '0));

  p_irq_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ien_q != '0));

  p_tx_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == IW'(1) && tx_full && !xfer_start_o)
      |=> (tx_cnt == $past(tx_cnt)));

  p_soft_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == IW'(2) && !bus_wdata_i[0])
      |=> (tx_cnt == '0 && rx_cnt == '0 && !irq_o && (&cs_n_o)));

  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr && bus_addr_i == IW'(6) && bus_wdata_i[4]) &&
     !(wr && bus_addr_i == IW'(2) && !bus_wdata_i[0])) |=> ovf_q);

  p_start_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (tx_cnt != '0));

  p_one_flight_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
endmodule

bind spi_reg_unit spi_reg_unit_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NCS(NCS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .irq_o        (irq_o),
  .cs_n_o       (cs_n_o),
  .xfer_start_o (xfer_start_o),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt),
  .tx_full      (tx_full),
  .ovf_q        (ovf_q),
  .ien_q        (ien_q)
);

// File: tb/spi_reg_unit_tb_top.sv
module spi_reg_unit_tb_top;
  localparam int D = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [11:2] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic irq_o;
  logic [3:0] cs_n_o;
  logic xfer_start_o;
  logic [31:0] xfer_tx_o;
  logic xfer_done_i = 1'b0;
  logic [31:0] xfer_rx_i = '0;

  always #5 clk_i = ~clk_i;

  spi_reg_unit #(.DEPTH(D), .ADDR_W(12), .NCS(4)) dut_i (.*);

  int checks = 0, fails = 0;
  string cur_req = "R12";

  // reference model
  logic [31:0] txq[$], rxq[$];
  logic [31:0] m_ctrl, m_cfg, m_ien, m_dma, m_per, m_test;
  bit m_ovf, m_tc, m_busy;
  // shifter model
  bit eng_busy; int eng_cnt; logic [31:0] eng_word;

  function automatic void m_clear();
    txq.delete(); rxq.delete();
    m_ctrl = 0; m_cfg = 0; m_ien = 0; m_dma = 0; m_per = 0; m_test = 0;
    m_ovf = 0; m_tc = 0; m_busy = 0;
  endfunction

  function automatic bit m_master();
    return m_ctrl[4 + int'(m_ctrl[19:18])];
  endfunction

  function automatic bit m_start();
    return m_ctrl[0] && m_master() && !m_busy && txq.size() > 0 &&
           (m_ctrl[2] || m_ctrl[3]);
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[0] = txq.size() == 0;
    s[1] = txq.size() == D;
    s[2] = rxq.size() != 0;
    s[3] = rxq.size() == D;
    s[4] = m_ovf;
    s[5] = m_tc;
    return s;
  endfunction

  function automatic logic [31:0] m_rdata();
    int ix = int'(bus_addr_i);
    if (!(bus_req_i && !bus_we_i)) return 0;
    case (ix)
      0: return (m_ctrl[0] && rxq.size() > 0) ? rxq[0] : 32'h0;
      2: return m_ctrl;
      3: return m_cfg;
      4: return m_ien;
      5: return m_dma;
      6: return m_status();
      7: return m_per;
      8: return m_test;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [3:0] ecs;
    ecs = m_master() ? ~(4'b1 << m_ctrl[19:18]) : 4'hF;
    chk("rdata", bus_rdata_o, m_rdata());
    chk("irq", {31'b0, irq_o}, {31'b0, |(m_status() & m_ien)});
    chk("cs_n", {28'b0, cs_n_o}, {28'b0, ecs});
    chk("start", {31'b0, xfer_start_o}, {31'b0, m_start()});
    if (m_start()) chk("tx_word", xfer_tx_o, txq[0]);
  endtask

  function automatic void m_update(input bit st);
    int ix = int'(bus_addr_i);
    bit wr = bus_req_i && bus_we_i, rd = bus_req_i && !bus_we_i;
    bit dn = xfer_done_i && m_busy;
    int txn = txq.size(), rxn = rxq.size();
    bit en = m_ctrl[0];
    if (wr && ix == 2 && !bus_wdata_i[0]) begin m_clear(); return; end
    if (st) void'(txq.pop_front());
    if (wr && ix == 1 && en && txn < D) txq.push_back(bus_wdata_i);
    if (rd && ix == 0 && en && rxn > 0) void'(rxq.pop_front());
    if (st) m_busy = 1; else if (dn) m_busy = 0;
    if (wr && ix == 6) begin
      if (bus_wdata_i[4]) m_ovf = 0;
      if (bus_wdata_i[5]) m_tc = 0;
    end
    if (dn) begin
      if (rxn == D) m_ovf = 1; else rxq.push_back(xfer_rx_i);
      if (txn == 0) begin m_tc = 1; m_ctrl[2] = 0; end
    end
    if (wr) case (ix)
      2: m_ctrl = bus_wdata_i;
      3: m_cfg  = bus_wdata_i;
      4: m_ien  = bus_wdata_i;
      5: m_dma  = bus_wdata_i;
      7: m_per  = bus_wdata_i;
      8: m_test = bus_wdata_i;
      default: ;
    endcase
  endfunction

  task automatic step(input bit r, input bit w, input int byte_off, input logic [31:0] d);
    bit st;
    xfer_done_i = eng_busy && eng_cnt == 0;
    xfer_rx_i   = eng_word ^ 32'h5A5A_0000;
    bus_req_i   = r;
    bus_we_i    = w;
    bus_addr_i  = 10'(byte_off >> 2);
    bus_wdata_i = d;
    #1 compare();
    st = m_start();
    @(posedge clk_i);
    m_update(st);
    if (xfer_done_i) eng_busy = 0;
    else if (eng_busy && eng_cnt > 0) eng_cnt--;
    if (st) begin eng_busy = 1; eng_cnt = 2; eng_word = xfer_tx_o; end
    @(negedge clk_i);
  endtask

  task automatic wr32(input int off, input logic [31:0] d); step(1, 1, off, d); endtask
  task automatic rd32(input int off); step(1, 0, off, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0); endtask

  initial begin
    m_clear(); eng_busy = 0; eng_cnt = 0; eng_word = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R12 reset state
    cur_req = "R12"; idle(2); rd32(6'h18); rd32(8);
    // R1 decode and plain registers
    cur_req = "R1";
    wr32(8, 32'h1);
    wr32(12, 32'hCAFE_0001); wr32(20, 32'h1234_5678);
    wr32(28, 32'h0BAD_F00D); wr32(32, 32'hFFFF_0000);
    rd32(12); rd32(20); rd32(28); rd32(32); rd32(8);
    rd32(40); rd32(60); wr32(48, 32'hDEAD_BEEF); rd32(12); rd32(48);
    // R6 data ports that read 0 or ignore writes
    cur_req = "R6";
    rd32(4); rd32(36); wr32(0, 32'h1111_1111); wr32(36, 32'h2222_2222);
    rd32(24); rd32(0);
    // R7 TX drop when disabled then when full
    cur_req = "R7";
    wr32(8, 32'h0); wr32(4, 32'hAAAA_0000); rd32(24);
    wr32(8, 32'h1);
    for (int i = 0; i < D + 1; i++) wr32(4, 32'h100 + i);
    rd32(24);
    // R2 live flags
    cur_req = "R2"; rd32(24);
    // R3 interrupt masking
    cur_req = "R3";
    wr32(16, 32'h2); idle(1); wr32(16, 32'h4); idle(1);
    // R9/R10 exchange launch on channel 2
    cur_req = "R10";
    wr32(8, 32'h0008_0045); idle(5);
    cur_req = "R9"; idle(1);
    cur_req = "R11"; idle(50); rd32(24); rd32(8);
    // R11 overflow on full RX
    wr32(4, 32'h0000_0777); wr32(8, 32'h0008_0045); idle(10); rd32(24);
    wr32(16, 32'h10); idle(1);
    // R4 write-one-to-clear
    cur_req = "R4";
    wr32(24, 32'h0000_000F); rd32(24);
    wr32(24, 32'h0000_0010); rd32(24);
    wr32(24, 32'h0000_0020); rd32(24);
    // R5 receive pops
    cur_req = "R5";
    for (int i = 0; i < D + 1; i++) rd32(0);
    rd32(24);
    // R9 non-master selection leaves selects high and no launch
    cur_req = "R9";
    wr32(8, 32'h0004_0049); wr32(4, 32'h0000_0ABC); idle(4);
    // R10 launch-on-write mode on channel 1
    cur_req = "R10";
    wr32(8, 32'h0004_0029); idle(8);
    wr32(4, 32'h0000_0DEF); wr32(4, 32'h0000_0123); idle(15);
    rd32(0); rd32(0); rd32(0); rd32(24);
    // R8 soft reset with a word in flight
    cur_req = "R8";
    wr32(12, 32'h5555_5555); wr32(16, 32'h3F);
    wr32(4, 32'h0000_0F0F); wr32(8, 32'h0); idle(5);
    rd32(24); rd32(8); rd32(12); rd32(16); rd32(20); rd32(28); rd32(32);
    // R5 read while disabled
    cur_req = "R5"; rd32(0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog all-requirements actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule